// File: doc/BRIEF.md
# Shadow Memory Region Decoder

This block sits beside a memory controller and decides, for every memory access in the first megabyte, whether internal DRAM serves the cycle or the external bus does. It is given the access address, a direction bit and three mapping bytes. One byte controls the legacy video window. The other two hold per-segment read and write enables for the eight 32 KB segments that cover C0000h–FFFFFh.

The decision is made combinationally and presented one clock later on two claim outputs. At most one of them is high. Two registered flags show whether any segment in the BIOS area (E0000h and up) is shadowed for reading or for writing. A one-cycle flush pulse marks every change of the routing-relevant configuration bits, so that a downstream cache of decode results can drop stale entries.

Top module: `shdw_map_decoder`

## Requirements
- R1: A valid access with an address below A0000h is always claimed internally, for reads and for writes.
- R2: In A0000h–BFFFFh, bit 1 of `vid_cfg` set routes both reads and writes internally; with that bit clear, both go external.
- R3: For C0000h–FFFFFh, the segment index is address bits 17:15. Segments 0–3 take their enables from `seg_cfg_lo` and segments 4–7 from `seg_cfg_hi`. In each byte, bit 2n enables internal read of local segment n and bit 2n+1 enables internal write.
- R4: Read and write routing of a segment are independent. A direction whose enable is clear goes external while the other direction of the same segment can be internal.
- R5: `bios_shadow_rd` is high one cycle after any of `seg_cfg_hi` bits 0, 2, 4 or 6 is set. `bios_shadow_wr` does the same for bits 1, 3, 5 or 7.
- R6: Claims appear on the clock edge after the access is presented. A cycle without `acc_valid` produces no claim.
- R7: For every valid access below 100000h, exactly one of `hit_int` and `hit_ext` is high.
- R8: A valid access at or above 100000h produces neither claim.
- R9: `map_flush` is high for one cycle after the routing-relevant bits change from their value in the previous cycle. These bits are `vid_cfg` bit 1 and all bits of both segment bytes, and they count as zero during reset.
- R10: Changes to `vid_cfg` bits other than bit 1 cause no flush and no change in routing.
- R11: While reset is held, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (24) | Byte address of the access |
| vid_cfg | input | 8 | Video window control; bit 1 routes the window internally |
| seg_cfg_lo | input | 8 | Read/write enable pairs for segments 0–3 |
| seg_cfg_hi | input | 8 | Read/write enable pairs for segments 4–7 |
| hit_int | output | 1 | Access claimed by internal DRAM (registered) |
| hit_ext | output | 1 | Access forwarded to external bus (registered) |
| bios_shadow_rd | output | 1 | Some BIOS-area segment is shadowed for read |
| bios_shadow_wr | output | 1 | Some BIOS-area segment is shadowed for write |
| map_flush | output | 1 | One-cycle pulse after a routing change |

## Verification
The hardest case to produce is a single segment whose read and write routing differ while its neighbours are configured the other way. Such a fault only shows when both directions of the same segment are exercised under the same configuration. The stimulus walks a lone enable bit across all eight segments and probes the first and last byte of each segment against an adjacent one. It then sets read-only and write-only pairs and issues both directions back to back. Flush behaviour is checked by changing only the ignored bits of the video byte and confirming that no pulse appears.

// File: rtl/shdw_pkg.sv
// Package: shared constants and the region type for the shadow decoder.
// Assumes a byte address whose bits 19:0 cover the first megabyte.
package shdw_pkg;
    localparam int NUM_SEG      = 8;
    localparam int SEG_IDX_W    = $clog2(NUM_SEG);
    localparam int SEG_PER_BYTE = 4;
    localparam int CFG_W        = 8;
    localparam int MAP_W        = 2 * CFG_W;
    localparam int VID_ROUTE_BIT = 1;

    typedef enum logic [1:0] {
        RGN_LOW    = 2'd0,
        RGN_VIDEO  = 2'd1,
        RGN_ROM    = 2'd2,
        RGN_BEYOND = 2'd3
    } region_e;
endpackage

// File: rtl/shdw_region_classify.sv
// Classifies an address into low memory, video window, ROM segment area or
// beyond the first megabyte, and extracts the 32 KB segment index.
// Assumes ADDR_W >= 21 so that addresses past 1 MB are visible.
module shdw_region_classify
    import shdw_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0]    addr,
    output region_e              region,
    output logic [SEG_IDX_W-1:0] seg_idx
);
    // Region decision from the upper address bits.
    always_comb begin
        if (addr[ADDR_W-1:20] != '0)
            region = RGN_BEYOND;
        else if (addr[19:18] == 2'b11)
            region = RGN_ROM;
        else if (addr[19:17] == 3'b101)
            region = RGN_VIDEO;
        else
            region = RGN_LOW;
    end

    assign seg_idx = addr[15 +: SEG_IDX_W];
endmodule

// File: rtl/shdw_seg_perm.sv
// Unpacks the two segment control bytes into per-segment read and write
// enables and derives the BIOS-area summary flags (upper half of segments).
// Assumes two bits per segment, read enable in the even bit.
module shdw_seg_perm
    import shdw_pkg::*;
(
    input  logic [CFG_W-1:0]   cfg_lo,
    input  logic [CFG_W-1:0]   cfg_hi,
    output logic [NUM_SEG-1:0] rd_en,
    output logic [NUM_SEG-1:0] wr_en,
    output logic               upper_rd,
    output logic               upper_wr
);
    logic [MAP_W-1:0] packed_map;
    assign packed_map = {cfg_hi, cfg_lo};

    for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
        assign rd_en[s] = packed_map[2*s];
        assign wr_en[s] = packed_map[2*s+1];
    end

    assign upper_rd = |rd_en[NUM_SEG-1:NUM_SEG/2];
    assign upper_wr = |wr_en[NUM_SEG-1:NUM_SEG/2];
endmodule

// File: rtl/shdw_flush_track.sv
// Remembers the routing-relevant configuration bits and pulses a flush one
// cycle after they differ from the previous cycle. Reset value is zero.
module shdw_flush_track #(
    parameter int TRK_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TRK_W-1:0] tracked,
    output logic             flush
);
    logic [TRK_W-1:0] prev_q;

    // Capture the previous configuration and flag any difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            flush  <= 1'b0;
        end else begin
            prev_q <= tracked;
            flush  <= (tracked != prev_q);
        end
    end
endmodule

// File: rtl/shdw_map_decoder.sv
// Top of the shadow region decoder: routes each access to internal DRAM or
// the external bus from three mapping bytes, registers the result, and
// reports BIOS-area shadow state and configuration-change flushes.
// Assumes inputs are stable around the rising clock edge.
module shdw_map_decoder
    import shdw_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [CFG_W-1:0]  vid_cfg,
    input  logic [CFG_W-1:0]  seg_cfg_lo,
    input  logic [CFG_W-1:0]  seg_cfg_hi,
    output logic              hit_int,
    output logic              hit_ext,
    output logic              bios_shadow_rd,
    output logic              bios_shadow_wr,
    output logic              map_flush
);
    region_e              region;
    logic [SEG_IDX_W-1:0] seg_idx;
    logic [NUM_SEG-1:0]   rd_en, wr_en;
    logic                 upper_rd, upper_wr;
    logic                 int_d, ext_d;
    logic                 armed_q;

    shdw_region_classify #(.ADDR_W(ADDR_W)) u_cls (
        .addr(acc_addr), .region(region), .seg_idx(seg_idx)
    );

    shdw_seg_perm u_perm (
        .cfg_lo(seg_cfg_lo), .cfg_hi(seg_cfg_hi),
        .rd_en(rd_en), .wr_en(wr_en),
        .upper_rd(upper_rd), .upper_wr(upper_wr)
    );

    shdw_flush_track #(.TRK_W(MAP_W + 1)) u_flush (
        .clk(clk), .rst_n(rst_n),
        .tracked({vid_cfg[VID_ROUTE_BIT], seg_cfg_hi, seg_cfg_lo}),
        .flush(map_flush)
    );

    // Combinational routing decision for the presented access.
    always_comb begin
        int_d = 1'b0;
        unique case (region)
            RGN_LOW:    int_d = 1'b1;
            RGN_VIDEO:  int_d = vid_cfg[VID_ROUTE_BIT];
            RGN_ROM:    int_d = acc_write ? wr_en[seg_idx] : rd_en[seg_idx];
            default:    int_d = 1'b0;
        endcase
        ext_d = acc_valid && (region != RGN_BEYOND) && !int_d;
        int_d = acc_valid && int_d;
    end

    // Register claims and BIOS-area flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_int        <= 1'b0;
            hit_ext        <= 1'b0;
            bios_shadow_rd <= 1'b0;
            bios_shadow_wr <= 1'b0;
            armed_q        <= 1'b0;
        end else begin
            hit_int        <= int_d;
            hit_ext        <= ext_d;
            bios_shadow_rd <= upper_rd;
            bios_shadow_wr <= upper_wr;
            armed_q        <= 1'b1;
        end
    end

    // R7: the two claims never coexist.
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_int && hit_ext));

    // R1: low memory is claimed internally one cycle later.
    a_r1_low_internal: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(acc_valid) && ($past(acc_addr) < ADDR_W'(20'hA0000))
        |-> hit_int);

    // R8: beyond the first megabyte nothing is claimed.
    a_r8_beyond_silent: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(acc_valid) && ($past(acc_addr) >= ADDR_W'(24'h100000))
        |-> !hit_int && !hit_ext);

    // R6: idle cycles leave both claims low.
    a_r6_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && !$past(acc_valid) |-> !hit_int && !hit_ext);

    // R7: a valid access inside 1 MB is claimed by one side.
    a_r7_claimed: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && $past(acc_valid) && ($past(acc_addr) < ADDR_W'(24'h100000))
        |-> (hit_int || hit_ext));
endmodule

// File: tb/sim_shdw_map_decoder.sv
`timescale 1ns/1ps
module sim_shdw_map_decoder;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0, acc_write = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [7:0]    vid_cfg = 8'h00, seg_cfg_lo = 8'h00, seg_cfg_hi = 8'h00;
    logic          hit_int, hit_ext, bios_shadow_rd, bios_shadow_wr, map_flush;

    int checks = 0, failures = 0;
    logic [16:0] prev_trk = '0;

    logic [4:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    shdw_map_decoder #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .vid_cfg(vid_cfg), .seg_cfg_lo(seg_cfg_lo),
        .seg_cfg_hi(seg_cfg_hi), .hit_int(hit_int), .hit_ext(hit_ext),
        .bios_shadow_rd(bios_shadow_rd), .bios_shadow_wr(bios_shadow_wr),
        .map_flush(map_flush)
    );

    task automatic check1(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    // Reference routing, written from the address map in numeric form.
    function automatic logic model_int(int unsigned a, logic wr);
        int unsigned seg;
        logic [15:0] m;
        m = {seg_cfg_hi, seg_cfg_lo};
        if (a < 32'hA0000) return 1'b1;
        if (a < 32'hC0000) return vid_cfg[1];
        seg = (a - 32'hC0000) / 32'h8000;
        return wr ? m[seg*2+1] : m[seg*2];
    endfunction

    // Driver: present one cycle of stimulus and queue its expected result.
    task automatic issue(string tag, logic v, logic wr, int unsigned a);
        logic ei, ee, er, ew, ef;
        logic [16:0] trk;
        acc_valid = v; acc_write = wr; acc_addr = AW'(a);
        ei = 1'b0; ee = 1'b0;
        if (v && a < 32'h100000) begin
            ei = model_int(a, wr);
            ee = !ei;
        end
        er = seg_cfg_hi[0] | seg_cfg_hi[2] | seg_cfg_hi[4] | seg_cfg_hi[6];
        ew = seg_cfg_hi[1] | seg_cfg_hi[3] | seg_cfg_hi[5] | seg_cfg_hi[7];
        trk = {vid_cfg[1], seg_cfg_hi, seg_cfg_lo};
        ef = (trk != prev_trk);
        prev_trk = trk;
        exp_q.push_back({ei, ee, er, ew, ef});
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: compare each registered result after the edge that made it.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && exp_q.size() > 0) begin
                logic [4:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check1(t, "hit_int", hit_int, e[4]);
                check1(t, "hit_ext", hit_ext, e[3]);
                check1(t, "bios_shadow_rd", bios_shadow_rd, e[2]);
                check1(t, "bios_shadow_wr", bios_shadow_wr, e[1]);
                check1(t, "map_flush", map_flush, e[0]);
            end
        end
    end

    initial begin
        #(5ns * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R11: outputs low under reset, even with traffic present.
        acc_valid = 1'b1; acc_addr = AW'(32'h10);
        repeat (3) @(negedge clk);
        check1("R11", "hit_int", hit_int, 1'b0);
        check1("R11", "hit_ext", hit_ext, 1'b0);
        check1("R11", "map_flush", map_flush, 1'b0);
        check1("R11", "bios_shadow_rd", bios_shadow_rd, 1'b0);
        rst_n = 1'b1;

        // R1: low memory both directions.
        issue("R1", 1, 0, 32'h00000);
        issue("R1", 1, 1, 32'h9FFFF);
        // R2: video window external then internal.
        issue("R2", 1, 0, 32'hA0000);
        issue("R2", 1, 1, 32'hBFFFF);
        vid_cfg = 8'h02;
        issue("R9", 1, 0, 32'hA0000);
        issue("R2", 1, 1, 32'hBFFFF);
        // R10: other video bits change, no flush, routing kept.
        vid_cfg = 8'hFF;
        issue("R10", 1, 0, 32'hB0000);
        vid_cfg = 8'hFD;
        issue("R9", 1, 1, 32'hA8000);
        vid_cfg = 8'h00;
        issue("R10", 1, 1, 32'hA8000);
        // R3: walk a lone read enable across all segments.
        for (int s = 0; s < 8; s++) begin
            logic [15:0] m;
            m = 16'h1 << (2*s);
            {seg_cfg_hi, seg_cfg_lo} = m;
            issue("R3", 1, 0, 32'hC0000 + s*32'h8000);
            issue("R3", 1, 0, 32'hC7FFF + s*32'h8000);
            issue("R3", 1, 0, 32'hC0000 + ((s+1)%8)*32'h8000);
            issue("R4", 1, 1, 32'hC0000 + s*32'h8000);
        end
        // R4: write-only and read-only segments.
        seg_cfg_lo = 8'h02; seg_cfg_hi = 8'h40;
        issue("R4", 1, 0, 32'hC0000);
        issue("R4", 1, 1, 32'hC0000);
        issue("R4", 1, 1, 32'hF8000);
        issue("R4", 1, 0, 32'hFFFFF);
        // R5: BIOS-area flags.
        seg_cfg_lo = 8'hFF; seg_cfg_hi = 8'h00;
        issue("R5", 1, 0, 32'hE0000);
        seg_cfg_hi = 8'h10;
        issue("R5", 1, 0, 32'hF0000);
        seg_cfg_hi = 8'hAA;
        issue("R5", 1, 1, 32'hE8000);
        issue("R5", 1, 1, 32'hE8000);
        // R8: beyond 1 MB.
        issue("R8", 1, 0, 32'h100000);
        issue("R8", 1, 1, 32'hFFFFFF);
        // R6: idle cycles.
        issue("R6", 0, 0, 32'h00100);
        issue("R6", 0, 1, 32'hC0000);
        issue("R7", 1, 0, 32'hD0000);
        issue("R6", 0, 0, 32'h0);
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule